// File: doc/BRIEF.md
# Radio Operating-Mode Controller

This block holds the radio's operating-mode control register and the state machine that follows it. The host writes an 8-bit mode word. Three of its bits request the crystal oscillator, the frequency synthesizer and the transmitter. The controller turns that request into enable signals for the three analog blocks and reports the current operating state as a 2-bit code.

A transmit request raises the enables in order: first the oscillator, then the synthesizer. The transmitter is enabled only after the synthesizer reports that it has settled. Once in TX, the controller stays there until the packet-sent pulse arrives. At that point it clears the transmit request bit on its own. It then drops to TUNE if the synthesizer bit is still set, and to READY in every other case. It never falls back to STANDBY by itself, so the oscillator keeps running until the host explicitly writes an all-zero mode word.

Internal states and codes: STANDBY (00), READY (01), TUNE (10), TX_OSC (reported 01), TX_SYN (reported 10), TX (11). Transitions:
- write → decoded state;
- TX_OSC → TX_SYN;
- TX_SYN → TX when the synthesizer is ready;
- TX → TUNE or READY on packet-sent;
- otherwise hold.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset the mode register reads 00h, the state code is 00 (STANDBY) and the oscillator, synthesizer and transmitter enables are all low.
- R2: A host write stores all 8 bits, and the register reads them back unchanged from the cycle after the write. Bit 0 requests the oscillator, bit 1 requests the synthesizer and bit 3 requests transmit. The remaining bits are stored only.
- R3: A write with bit 3 clear selects one of three states. With bit 1 set it selects TUNE (code 10, oscillator and synthesizer on). Otherwise, with bit 0 set, it selects READY (code 01, oscillator only). Otherwise it selects STANDBY (code 00, all enables off). The new state applies from the cycle after the write, and writing 00h reaches STANDBY from any state.
- R4: A write with bit 3 set starts the transmit sequence. One cycle after the write the oscillator alone is on (code 01). One cycle later the synthesizer is also on (code 10), and the block holds there while the synthesizer-ready input is low. The cycle after synthesizer-ready is sampled high, the transmitter is enabled as well (code 11).
- R5: A packet-sent pulse in TX clears bit 3 of the mode register and leaves every other bit as it was.
- R6: After a packet-sent pulse in TX, the state becomes TUNE if bit 1 is set and READY otherwise, so a mode word of 08h ends in READY with the oscillator still on.
- R7: A packet-sent pulse while the state is not TX, including during the transmit start-up, changes neither the register nor the state.
- R8: Without a packet-sent pulse, TX is held for as long as needed.
- R9: After the automatic exit from TX, the block stays in READY or TUNE until the host writes the register. It reaches STANDBY only through a write of 00h.
- R10: When a host write and a packet-sent pulse arrive in the same cycle, the write decides both the register value and the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the mode register |
| wr_data | input | 8 | Mode word to write |
| pkt_sent | input | 1 | Single-cycle packet-sent event |
| synth_ready | input | 1 | Synthesizer settled indication |
| mode_q | output | 8 | Current mode register contents |
| osc_en | output | 1 | Crystal oscillator enable |
| synth_en | output | 1 | Synthesizer enable |
| tx_en | output | 1 | Transmitter enable |
| state_code | output | 2 | Operating state: 00 STANDBY, 01 READY, 10 TUNE, 11 TX |

## Verification
Every result is due exactly one clock edge after the input that causes it. The register and the state both update on that edge, and the enables and state code are decoded directly from the state. The transmit sequence therefore advances one step per edge: oscillator, then synthesizer, then transmitter one edge after synthesizer-ready is seen high. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sees the single rising edge that should have produced its value. Checks for ignored pulses and for holding in TX repeat the sample over several such intervals.

// File: rtl/radio_mode_pkg.sv
package radio_mode_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_READY,
        ST_TUNE,
        ST_TX_OSC,
        ST_TX_SYN,
        ST_TX
    } mode_state_e;

    localparam int CODE_W = 2;
    localparam logic [CODE_W-1:0] CODE_STANDBY = 2'b00;
    localparam logic [CODE_W-1:0] CODE_READY   = 2'b01;
    localparam logic [CODE_W-1:0] CODE_TUNE    = 2'b10;
    localparam logic [CODE_W-1:0] CODE_TX      = 2'b11;

endpackage

// File: rtl/radio_mode_reg.sv
module radio_mode_reg #(
    parameter int REG_W  = 8,
    parameter int TX_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             clr_tx,
    output logic [REG_W-1:0] mode_q
);

    // Host write wins over the self-clear of the transmit request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_data;
        end else if (clr_tx) begin
            mode_q[TX_BIT] <= 1'b0;
        end
    end

endmodule

// File: rtl/radio_mode_fsm.sv
module radio_mode_fsm
    import radio_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_osc,
    input  logic              wr_tune,
    input  logic              wr_tx,
    input  logic              cur_tune,
    input  logic              pkt_sent,
    input  logic              synth_ready,
    output logic              pkt_done,
    output logic              osc_en,
    output logic              synth_en,
    output logic              tx_en,
    output logic [CODE_W-1:0] state_code
);

    mode_state_e state, state_nx;

    // Next-state decision and state register.
    always_comb begin
        state_nx = state;
        if (wr_en) begin
            if (wr_tx) begin
                state_nx = ST_TX_OSC;
            end else if (wr_tune) begin
                state_nx = ST_TUNE;
            end else if (wr_osc) begin
                state_nx = ST_READY;
            end else begin
                state_nx = ST_STANDBY;
            end
        end else begin
            unique case (state)
                ST_STANDBY: state_nx = ST_STANDBY;
                ST_READY:   state_nx = ST_READY;
                ST_TUNE:    state_nx = ST_TUNE;
                ST_TX_OSC:  state_nx = ST_TX_SYN;
                ST_TX_SYN:  state_nx = synth_ready ? ST_TX : ST_TX_SYN;
                ST_TX: begin
                    if (pkt_sent) begin
                        state_nx = cur_tune ? ST_TUNE : ST_READY;
                    end
                end
                default:    state_nx = ST_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STANDBY;
        end else begin
            state <= state_nx;
        end
    end

    // Output decode from the current state.
    always_comb begin
        osc_en     = 1'b0;
        synth_en   = 1'b0;
        tx_en      = 1'b0;
        state_code = CODE_STANDBY;
        unique case (state)
            ST_STANDBY: state_code = CODE_STANDBY;
            ST_READY: begin
                osc_en     = 1'b1;
                state_code = CODE_READY;
            end
            ST_TUNE: begin
                osc_en     = 1'b1;
                synth_en   = 1'b1;
                state_code = CODE_TUNE;
            end
            ST_TX_OSC: begin
                osc_en     = 1'b1;
                state_code = CODE_READY;
            end
            ST_TX_SYN: begin
                osc_en     = 1'b1;
                synth_en   = 1'b1;
                state_code = CODE_TUNE;
            end
            ST_TX: begin
                osc_en     = 1'b1;
                synth_en   = 1'b1;
                tx_en      = 1'b1;
                state_code = CODE_TX;
            end
            default: state_code = CODE_STANDBY;
        endcase
    end

    assign pkt_done = (state == ST_TX) && pkt_sent;

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
    import radio_mode_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int OSC_BIT  = 0,
    parameter int TUNE_BIT = 1,
    parameter int TX_BIT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pkt_sent,
    input  logic             synth_ready,
    output logic [REG_W-1:0] mode_q,
    output logic             osc_en,
    output logic             synth_en,
    output logic             tx_en,
    output logic [1:0]       state_code
);

    logic pkt_done;

    radio_mode_reg #(
        .REG_W  (REG_W),
        .TX_BIT (TX_BIT)
    ) i_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr_tx  (pkt_done),
        .mode_q  (mode_q)
    );

    radio_mode_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_osc      (wr_data[OSC_BIT]),
        .wr_tune     (wr_data[TUNE_BIT]),
        .wr_tx       (wr_data[TX_BIT]),
        .cur_tune    (mode_q[TUNE_BIT]),
        .pkt_sent    (pkt_sent),
        .synth_ready (synth_ready),
        .pkt_done    (pkt_done),
        .osc_en      (osc_en),
        .synth_en    (synth_en),
        .tx_en       (tx_en),
        .state_code  (state_code)
    );

endmodule

// File: rtl/radio_mode_ctrl_chk.sv
module radio_mode_ctrl_chk #(
    parameter int REG_W  = 8,
    parameter int TX_BIT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             pkt_sent,
    input logic             synth_ready,
    input logic [REG_W-1:0] mode_q,
    input logic             osc_en,
    input logic             synth_en,
    input logic             tx_en,
    input logic [1:0]       state_code
);

    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mode_q == $past(wr_data)); // R2

    AST_STANDBY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b00) |-> (!osc_en && !synth_en && !tx_en)); // R3

    AST_TX_ENABLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (osc_en && synth_en)); // R4

    AST_TX_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(synth_ready)); // R4

    AST_SENT_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b11 && pkt_sent && !wr_en) |=> !mode_q[TX_BIT]); // R5

    AST_PULSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'b11 && pkt_sent && !wr_en) |=> $stable(mode_q)); // R7

    AST_NO_SELF_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'b00 && !wr_en) |=> state_code != 2'b00); // R9

endmodule

bind radio_mode_ctrl radio_mode_ctrl_chk #(
    .REG_W  (REG_W),
    .TX_BIT (TX_BIT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .pkt_sent    (pkt_sent),
    .synth_ready (synth_ready),
    .mode_q      (mode_q),
    .osc_en      (osc_en),
    .synth_en    (synth_en),
    .tx_en       (tx_en),
    .state_code  (state_code)
);

// File: tb/test_radio_mode_ctrl.sv
module test_radio_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pkt_sent = 1'b0;
    logic       synth_ready = 1'b0;
    logic [7:0] mode_q;
    logic       osc_en, synth_en, tx_en;
    logic [1:0] state_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    radio_mode_ctrl i_radio_mode_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .pkt_sent    (pkt_sent),
        .synth_ready (synth_ready),
        .mode_q      (mode_q),
        .osc_en      (osc_en),
        .synth_en    (synth_en),
        .tx_en       (tx_en),
        .state_code  (state_code)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Compare enables as {osc,synth,tx}, state code and register.
    task automatic expect_all(input string req, input logic [2:0] en,
                              input logic [1:0] code, input logic [7:0] reg_v);
        check(req, {29'd0, osc_en, synth_en, tx_en}, {29'd0, en});
        check(req, {30'd0, state_code}, {30'd0, code});
        check(req, {24'd0, mode_q}, {24'd0, reg_v});
    endtask

    // Drive at a falling edge; return at the next falling edge.
    task automatic host_write(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_sent();
        pkt_sent = 1'b1;
        @(negedge clk);
        pkt_sent = 1'b0;
    endtask

    // Bring to TX from a write v, checking each step.
    task automatic go_tx(input logic [7:0] v, input string req);
        synth_ready = 1'b0;
        host_write(v);
        expect_all(req, 3'b100, 2'b01, v);
        @(negedge clk);
        expect_all(req, 3'b110, 2'b10, v);
        @(negedge clk);
        expect_all(req, 3'b110, 2'b10, v);
        synth_ready = 1'b1;
        @(negedge clk);
        expect_all(req, 3'b111, 2'b11, v);
        synth_ready = 1'b0;
    endtask

    task automatic t_reset();
        expect_all("R1 reset", 3'b000, 2'b00, 8'h00);
    endtask

    task automatic t_plain_modes();
        host_write(8'hA5);
        expect_all("R2/R3 ready A5", 3'b100, 2'b01, 8'hA5);
        host_write(8'hF2);
        expect_all("R2/R3 tune F2", 3'b110, 2'b10, 8'hF2);
        host_write(8'h00);
        expect_all("R3 standby", 3'b000, 2'b00, 8'h00);
        host_write(8'h70);
        expect_all("R2/R3 spare bits only", 3'b000, 2'b00, 8'h70);
        host_write(8'h00);
    endtask

    task automatic t_tx_only();
        synth_ready = 1'b0;
        host_write(8'h08);
        expect_all("R4 tx osc step", 3'b100, 2'b01, 8'h08);
        @(negedge clk);
        expect_all("R4 tx synth step", 3'b110, 2'b10, 8'h08);
        pulse_sent();
        expect_all("R7 pulse during startup", 3'b110, 2'b10, 8'h08);
        @(negedge clk);
        expect_all("R4 waits for synth", 3'b110, 2'b10, 8'h08);
        synth_ready = 1'b1;
        @(negedge clk);
        expect_all("R4 tx on", 3'b111, 2'b11, 8'h08);
        synth_ready = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            expect_all("R8 tx held", 3'b111, 2'b11, 8'h08);
        end
        pulse_sent();
        expect_all("R5/R6 08 ends in ready", 3'b100, 2'b01, 8'h00);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            expect_all("R9 stays ready", 3'b100, 2'b01, 8'h00);
        end
        host_write(8'h00);
        expect_all("R9 standby by write", 3'b000, 2'b00, 8'h00);
    endtask

    task automatic t_tx_tune();
        go_tx(8'h0A, "R4 tx from 0A");
        pulse_sent();
        expect_all("R6 0A ends in tune", 3'b110, 2'b10, 8'h02);
        @(negedge clk);
        expect_all("R9 stays tune", 3'b110, 2'b10, 8'h02);
        host_write(8'h00);
    endtask

    task automatic t_tx_osc_spare();
        go_tx(8'hC9, "R4 tx from C9");
        pulse_sent();
        expect_all("R5/R6 C9 keeps other bits", 3'b100, 2'b01, 8'hC1);
        host_write(8'h00);
    endtask

    task automatic t_idle_pulse();
        host_write(8'h01);
        pulse_sent();
        expect_all("R7 pulse in ready", 3'b100, 2'b01, 8'h01);
        host_write(8'h00);
        pulse_sent();
        expect_all("R7 pulse in standby", 3'b000, 2'b00, 8'h00);
    endtask

    task automatic t_collision();
        go_tx(8'h08, "R4 tx for collision");
        pkt_sent = 1'b1;
        host_write(8'h00);
        pkt_sent = 1'b0;
        expect_all("R10 write beats pulse", 3'b000, 2'b00, 8'h00);
        go_tx(8'h0A, "R4 tx for collision 2");
        pkt_sent = 1'b1;
        host_write(8'h08);
        pkt_sent = 1'b0;
        expect_all("R10 rewrite tx restarts", 3'b100, 2'b01, 8'h08);
        host_write(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_plain_modes();
        t_tx_only();
        t_tx_tune();
        t_tx_osc_spare();
        t_idle_pulse();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule